// File: doc/BRIEF.md
# Three-Strobe SAR ADC Host Sequencer

This block runs a 16-bit successive-approximation converter with a parallel output bus from the host side. The converter has only a chip-select strobe and a read/convert select line. Each sample needs three separate falling edges of chip select, and the select line means something different at each edge. At the first edge a low level wakes the converter and starts tracking. At the second edge tracking ends, conversion starts, and the level picks whether the reference stays powered (standby) or powers down (shutdown) once the conversion finishes. At the third edge a high level puts the result on the bus. The sequencer times all of this in system clocks. It waits for the synchronised end-of-conversion flag to fall, then reads the bus and hands one result word to the user.

A user asks for a sample by pulsing a start request while the block is idle. With the request it gives the power mode for that conversion and a flag saying whether the result is offset binary from a bipolar range. A bipolar word is turned into two's complement. If the reference may be cold, the block stretches the tracking interval to a long wake-up time. This applies after a shutdown-mode conversion, after reset and after a timeout. If the conversion flag never falls, the block gives up after a bounded wait and reports an error pulse instead of a result. After its own reset the block first pulses the converter's reset line while chip select is held high.

Top module: `adc_strobe_seq`

## Requirements
- R1: In idle, a high `start_i` at a clock edge is accepted. From the next cycle `busy_o` is high and chip select stays high for CSH_CLKS cycles before the first strobe.
- R2: The first strobe holds chip select low for CSL_CLKS cycles with `adc_rc_o` low. Chip select is never low while `busy_o` is low.
- R3: When the reference is known to be powered, the second falling edge of chip select comes exactly ACQ_CLKS cycles after the first. `adc_rc_o` equals the latched mode (1 = shutdown, 0 = standby) from the cycle before that edge and through the CSL_CLKS-cycle strobe. `adc_rc_o` never changes in the cycle where chip select falls.
- R4: After a shutdown-mode conversion, after reset and after a timeout, the spacing between the first and second falling edges is WAKE_CLKS cycles instead.
- R5: The end-of-conversion input passes through two flops. A falling edge of that input, seen in cycle e of the wait, ends the wait after cycle e+2. Chip select then stays high with `adc_rc_o` high for CSH_CLKS cycles, and the read strobe is low for RD_CLKS cycles with `adc_rc_o` high.
- R6: The bus is captured in the last cycle of the read strobe. `valid_o` is high for exactly one cycle, the same cycle in which chip select rises and `busy_o` falls.
- R7: When the bipolar flag latched at start is 1, `result_o` is the captured word with bit 15 inverted. When the flag is 0, `result_o` is the captured word unchanged.
- R8: If no falling edge arrives within TMO_CLKS wait cycles, `err_o` is high for one cycle with chip select high and `busy_o` low, and `valid_o` stays low. A falling edge in the last wait cycle still counts as a completed conversion.
- R9: A start request while `busy_o` is high has no effect. The sequence in progress is unchanged, and no new sequence starts after it.
- R10: While `rst_n` is low, and for RST_CLKS-1 cycles after it is released, `adc_reset_o` is high, chip select is high and `busy_o` is low.
- R11: A falling edge of the end-of-conversion input outside the wait for conversion does not change the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion (taken only when idle) |
| shdn_i | input | 1 | Power mode for this conversion: 1 shutdown, 0 standby |
| bipolar_i | input | 1 | 1: result is offset binary, convert to two's complement |
| result_o | output | 16 | Last result word |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | A conversion sequence is in progress |
| err_o | output | 1 | One-cycle strobe on conversion timeout |
| adc_cs_n_o | output | 1 | Converter chip select / strobe, active low |
| adc_rc_o | output | 1 | Converter read/convert select |
| adc_reset_o | output | 1 | Converter reset, active high |
| adc_eoc_i | input | 1 | Converter end-of-conversion flag, falls when done |
| adc_data_i | input | 16 | Converter parallel data bus |

## Verification
The assertions assume that the parameters give every strobe and gap at least one cycle. They also assume that ACQ_CLKS and WAKE_CLKS exceed CSL_CLKS plus one, so that the chip-select and select-line rules follow from the phase order alone. They also assume the end-of-conversion flag falls at most once per conversion and is high again well before the next wait. The bench converter model keeps within this. It raises the flag at the start of every sequence, drops it only at a chosen cycle of the wait or in one deliberate early pulse, and drives the bus only while the read strobe is low. The bench parameters meet every ordering the sequencer relies on.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [3:0] {
        ST_RST,
        ST_IDLE,
        ST_LEAD,
        ST_ACQ_LO,
        ST_ACQ_HI,
        ST_CNV_LO,
        ST_WAIT,
        ST_GAP,
        ST_RD_LO
    } seq_state_e;

endpackage

// File: rtl/adcseq_eoc_sync.sv
module adcseq_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_i,
    output logic fall_o
);
    // sh[0..STAGES-1] is the synchroniser chain, sh[STAGES] holds the previous level
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b1;
        else        sh_q[0] <= eoc_i;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[g] <= 1'b1;
            else        sh_q[g] <= sh_q[g-1];
        end
    end

    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/adcseq_fmt.sv
module adcseq_fmt #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] raw_i,
    input  logic          bipolar_i,
    output logic [DW-1:0] word_o
);
    // Offset binary to two's complement: flip the top bit only
    always_comb begin
        word_o         = raw_i;
        word_o[DW-1]   = raw_i[DW-1] ^ bipolar_i;
    end

endmodule

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq
    import adcseq_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CSL_CLKS  = 4,
    parameter int CSH_CLKS  = 4,
    parameter int ACQ_CLKS  = 200,
    parameter int WAKE_CLKS = 1200000,
    parameter int TMO_CLKS  = 600,
    parameter int RD_CLKS   = 4,
    parameter int RST_CLKS  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          shdn_i,
    input  logic          bipolar_i,
    output logic [DW-1:0] result_o,
    output logic          valid_o,
    output logic          busy_o,
    output logic          err_o,
    output logic          adc_cs_n_o,
    output logic          adc_rc_o,
    output logic          adc_reset_o,
    input  logic          adc_eoc_i,
    input  logic [DW-1:0] adc_data_i
);

    localparam int M1   = (WAKE_CLKS > TMO_CLKS) ? WAKE_CLKS : TMO_CLKS;
    localparam int M2   = (ACQ_CLKS > RST_CLKS) ? ACQ_CLKS : RST_CLKS;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXC = (M3 > RD_CLKS + CSL_CLKS + CSH_CLKS) ? M3 : RD_CLKS + CSL_CLKS + CSH_CLKS;
    localparam int CW   = $clog2(MAXC + 1);

    localparam logic [CW-1:0] LD_CSL  = CW'(CSL_CLKS - 1);
    localparam logic [CW-1:0] LD_CSH  = CW'(CSH_CLKS - 1);
    localparam logic [CW-1:0] LD_ACQ  = CW'(ACQ_CLKS - CSL_CLKS - 1);
    localparam logic [CW-1:0] LD_WAKE = CW'(WAKE_CLKS - CSL_CLKS - 1);
    localparam logic [CW-1:0] LD_TMO  = CW'(TMO_CLKS - 1);
    localparam logic [CW-1:0] LD_RD   = CW'(RD_CLKS - 1);
    localparam logic [CW-1:0] LD_RST  = CW'(RST_CLKS - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          ref_off;
        logic          mode;
        logic          bip;
        logic          cs_n;
        logic          rc;
        logic          rst_pin;
        logic          busy;
        logic          valid;
        logic          err;
        logic [DW-1:0] res;
    } seq_regs_t;

    seq_regs_t     seq_d, seq_q;
    logic          eoc_fall;
    logic [DW-1:0] fmt_word;
    logic          last_tick;

    adcseq_eoc_sync #(.STAGES(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .eoc_i  (adc_eoc_i),
        .fall_o (eoc_fall)
    );

    adcseq_fmt #(.DW(DW)) i_fmt (
        .raw_i     (adc_data_i),
        .bipolar_i (seq_q.bip),
        .word_o    (fmt_word)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        seq_d.err   = 1'b0;
        last_tick   = (seq_q.cnt == '0);
        if (!last_tick) seq_d.cnt = seq_q.cnt - 1'b1;

        unique case (seq_q.st)
            ST_RST: begin
                if (last_tick) seq_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st   = ST_LEAD;
                    seq_d.cnt  = LD_CSH;
                    seq_d.mode = shdn_i;
                    seq_d.bip  = bipolar_i;
                end
            end
            ST_LEAD: begin
                if (last_tick) begin
                    seq_d.st  = ST_ACQ_LO;
                    seq_d.cnt = LD_CSL;
                end
            end
            ST_ACQ_LO: begin
                if (last_tick) begin
                    seq_d.st  = ST_ACQ_HI;
                    seq_d.cnt = seq_q.ref_off ? LD_WAKE : LD_ACQ;
                end
            end
            ST_ACQ_HI: begin
                if (last_tick) begin
                    seq_d.st  = ST_CNV_LO;
                    seq_d.cnt = LD_CSL;
                end
            end
            ST_CNV_LO: begin
                if (last_tick) begin
                    seq_d.st      = ST_WAIT;
                    seq_d.cnt     = LD_TMO;
                    seq_d.ref_off = seq_q.mode;
                end
            end
            ST_WAIT: begin
                if (eoc_fall) begin
                    seq_d.st  = ST_GAP;
                    seq_d.cnt = LD_CSH;
                end else if (last_tick) begin
                    seq_d.st      = ST_IDLE;
                    seq_d.err     = 1'b1;
                    seq_d.ref_off = 1'b1;
                end
            end
            ST_GAP: begin
                if (last_tick) begin
                    seq_d.st  = ST_RD_LO;
                    seq_d.cnt = LD_RD;
                end
            end
            ST_RD_LO: begin
                if (last_tick) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.res   = fmt_word;
                    seq_d.valid = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        // Pin levels follow the next phase so they leave straight from flops
        seq_d.cs_n    = !(seq_d.st inside {ST_ACQ_LO, ST_CNV_LO, ST_RD_LO});
        seq_d.rst_pin = (seq_d.st == ST_RST);
        seq_d.busy    = (seq_d.st inside {ST_LEAD, ST_ACQ_LO, ST_ACQ_HI, ST_CNV_LO,
                                          ST_WAIT, ST_GAP, ST_RD_LO});
        if (seq_d.st inside {ST_ACQ_HI, ST_CNV_LO})
            seq_d.rc = seq_d.mode;
        else if (seq_d.st inside {ST_WAIT, ST_GAP, ST_RD_LO})
            seq_d.rc = 1'b1;
        else
            seq_d.rc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st      <= ST_RST;
            seq_q.cnt     <= LD_RST;
            seq_q.ref_off <= 1'b1;
            seq_q.mode    <= 1'b0;
            seq_q.bip     <= 1'b0;
            seq_q.cs_n    <= 1'b1;
            seq_q.rc      <= 1'b0;
            seq_q.rst_pin <= 1'b1;
            seq_q.busy    <= 1'b0;
            seq_q.valid   <= 1'b0;
            seq_q.err     <= 1'b0;
            seq_q.res     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign result_o    = seq_q.res;
    assign valid_o     = seq_q.valid;
    assign busy_o      = seq_q.busy;
    assign err_o       = seq_q.err;
    assign adc_cs_n_o  = seq_q.cs_n;
    assign adc_rc_o    = seq_q.rc;
    assign adc_reset_o = seq_q.rst_pin;

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic valid_o,
    input logic err_o,
    input logic adc_cs_n_o,
    input logic adc_rc_o,
    input logic adc_reset_o
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);                                           // R6

    AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (adc_cs_n_o && !busy_o));                            // R6

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);                                               // R8

    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!valid_o && adc_cs_n_o && !busy_o));                  // R8

    AST_CS_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n_o |-> busy_o);                                         // R2

    AST_RC_STEADY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n_o) |-> $stable(adc_rc_o));                        // R3

    AST_RESET_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset_o |-> (adc_cs_n_o && !busy_o));                        // R10

endmodule

bind adc_strobe_seq adcseq_checker i_adcseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .valid_o     (valid_o),
    .err_o       (err_o),
    .adc_cs_n_o  (adc_cs_n_o),
    .adc_rc_o    (adc_rc_o),
    .adc_reset_o (adc_reset_o)
);

// File: tb/test_adc_strobe_seq.sv
module test_adc_strobe_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CSL  = 3;
    localparam int CSH  = 2;
    localparam int ACQ  = 12;
    localparam int WAKE = 40;
    localparam int TMO  = 20;
    localparam int RD   = 4;
    localparam int RSTC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        shdn_i = 1'b0;
    logic        bipolar_i = 1'b0;
    logic [15:0] result_o;
    logic        valid_o, busy_o, err_o;
    logic        adc_cs_n_o, adc_rc_o, adc_reset_o;
    logic        adc_eoc_i = 1'b1;
    logic [15:0] adc_data_i = 16'hDEAD;

    adc_strobe_seq #(
        .DW(16), .CSL_CLKS(CSL), .CSH_CLKS(CSH), .ACQ_CLKS(ACQ),
        .WAKE_CLKS(WAKE), .TMO_CLKS(TMO), .RD_CLKS(RD), .RST_CLKS(RSTC)
    ) i_adc_strobe_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .shdn_i(shdn_i),
        .bipolar_i(bipolar_i), .result_o(result_o), .valid_o(valid_o),
        .busy_o(busy_o), .err_o(err_o), .adc_cs_n_o(adc_cs_n_o),
        .adc_rc_o(adc_rc_o), .adc_reset_o(adc_reset_o),
        .adc_eoc_i(adc_eoc_i), .adc_data_i(adc_data_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        cs;
        logic        rc;
        logic        busy;
        logic        valid;
        logic        err;
        logic        rpin;
        logic [15:0] res;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          done = 0;
    bit          ref_cold = 1;
    logic [15:0] cur_raw = 16'h0;

    function automatic void push(int n, logic cs, logic rc, logic busy, logic rpin, string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.cs = cs; e.rc = rc; e.busy = busy; e.valid = 1'b0; e.err = 1'b0;
            e.rpin = rpin; e.res = 16'h0; e.tag = tag;
            expq.push_back(e);
        end
    endfunction

    function automatic void push_end(logic v, logic er, logic [15:0] res, string tag);
        exp_t e;
        e.cs = 1'b1; e.rc = 1'b0; e.busy = 1'b0; e.valid = v; e.err = er;
        e.rpin = 1'b0; e.res = res; e.tag = tag;
        expq.push_back(e);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One cycle: compare the outputs of the last edge, then act as the converter bus
    task automatic step();
        exp_t e;
        logic [5:0] act, exv;
        @(negedge clk);
        if (expq.size() > 0) e = expq.pop_front();
        else begin
            e.cs = 1'b1; e.rc = 1'b0; e.busy = 1'b0; e.valid = 1'b0; e.err = 1'b0;
            e.rpin = 1'b0; e.res = 16'h0; e.tag = "R9";
        end
        act = {adc_cs_n_o, adc_rc_o, busy_o, valid_o, err_o, adc_reset_o};
        exv = {e.cs, e.rc, e.busy, e.valid, e.err, e.rpin};
        checks++;
        if (act !== exv) begin
            errors++;
            $display("FAIL %s cycle %0d cs/rc/busy/valid/err/rst got %b expected %b",
                     e.tag, cycles, act, exv);
        end
        if (e.valid) begin
            checks++;
            if (result_o !== e.res) begin
                errors++;
                $display("FAIL %s cycle %0d result got %h expected %h",
                         e.tag, cycles, result_o, e.res);
            end
        end
        if (!adc_cs_n_o && adc_rc_o) adc_data_i = cur_raw;
        else                         adc_data_i = 16'hDEAD;
    endtask

    task automatic convert(input bit shdn, input bit bip, input int e_del,
                           input logic [15:0] raw, input bit early);
        int          span;
        int          wstart;
        string       span_tag;
        logic [15:0] expv;
        span     = ref_cold ? WAKE : ACQ;
        span_tag = ref_cold ? "R4" : "R3";
        wstart   = CSH + span + CSL;
        expv     = bip ? (raw ^ 16'h8000) : raw;
        cur_raw  = raw;
        adc_eoc_i = 1'b1;
        push(CSH, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
        push(CSL, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
        push(span - CSL, 1'b1, shdn, 1'b1, 1'b0, early ? "R11" : span_tag);
        push(CSL, 1'b0, shdn, 1'b1, 1'b0, "R3");
        if (e_del >= 0) begin
            push(e_del + 3, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
            push(CSH, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
            push(RD, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
            push_end(1'b1, 1'b0, expv, bip ? "R7" : "R6");
        end else begin
            push(TMO, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
            push_end(1'b0, 1'b1, 16'h0, "R8");
        end
        start_i = 1'b1; shdn_i = shdn; bipolar_i = bip;
        for (int i = 0; expq.size() > 0; i++) begin
            step();
            start_i = (i == CSH + CSL + 1);          // R9: request while busy
            if (early && i == CSH + CSL)     adc_eoc_i = 1'b0;   // R11
            if (early && i == CSH + CSL + 3) adc_eoc_i = 1'b1;
            if (e_del >= 0 && i == wstart + e_del) adc_eoc_i = 1'b0;
        end
        start_i = 1'b0; shdn_i = 1'b0; bipolar_i = 1'b0;
        ref_cold = (e_del < 0) ? 1'b1 : shdn;
        for (int k = 0; k < 4; k++) step();           // R9: nothing follows
    endtask

    initial begin
        // R10: reset pulse on the converter while chip select is high
        push(3, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        for (int k = 0; k < 3; k++) step();
        rst_n = 1'b1;
        push(RSTC - 1, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        for (int k = 0; k < RSTC + 2; k++) step();

        convert(1'b0, 1'b0, 2,  16'h1234, 1'b0);    // cold after reset, R4 R6
        convert(1'b1, 1'b1, 5,  16'h0005, 1'b0);    // warm spacing R3, bipolar R7
        convert(1'b0, 1'b1, 1,  16'h8000, 1'b1);    // wake after shutdown R4, early EOC R11
        convert(1'b0, 1'b0, 0,  16'hFFFF, 1'b0);    // warm, fastest EOC R5
        convert(1'b0, 1'b0, -1, 16'hAAAA, 1'b0);    // timeout R8
        convert(1'b0, 1'b1, TMO - 3, 16'h7FFF, 1'b0); // cold after timeout, last-cycle EOC R8
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d got running expected finished", cycles);
            finish_run();
        end
    end

endmodule